// File: doc/BRIEF.md
# Word Sync Sequence Controller

This block is the per-channel control stage in front of a character encoder. In every character cycle it reads a two-bit control field, an optional select bit, a data byte and that byte's parity bit. It then tells the encoder which kind of character to send: the encoded data byte, a fill comma, a special code, one step of a sixteen-character word sync sequence, or a violation symbol. The actual 8b/10b codes, serialization, clock choice and lane bonding are handled elsewhere.

A sync sequence starts with one start character and runs for fifteen more cycles. There are two ways to run it. In atomic mode the sequence always runs to its end, and parity is checked only on the start character. In interruptible mode the sequence continues only while the control field stays quiet (00) and every character has correct parity. The outputs are registered. They carry a character-kind code, a step index from 0 to 15 that downstream logic uses to pick the character, and the data byte passed through.

Top module: `wsync_ctrl`

## Requirements
- R1: While `rst` is high at a rising edge, the outputs become kind 1 (fill), step 0 and data 0, and no sequence is in progress afterwards.
- R2: Every output reflects the inputs sampled at the previous rising edge, and `data_o` equals the `data_i` of that edge.
- R3: With `sel_enc_i`=0, control 00 gives kind 0 (data), 01 gives kind 1 (fill), 10 gives kind 2 (special), and 11 starts a sync sequence.
- R4: With `sel_enc_i`=1, `ctl_i[0]`=0 gives kind 0 whatever the select bit is. Select 0 with control 01 gives kind 1. Select 0 with control 11 gives kind 2. Select 1 with `ctl_i[0]`=1 starts a sync sequence.
- R5: A started sequence outputs kind 3 (sync) with step 0 on its start character. Steps 1 to 15 follow in consecutive cycles if nothing breaks it.
- R6: In atomic mode (`intr_mode_i`=0), the fifteen characters after the start give kind 3 with the next step, whatever the control, select and parity inputs are.
- R7: A start condition sampled in the cycle right after step 15 begins a new sequence at step 0.
- R8: With parity checking on (`par_chk_i`=1), a start character with bad odd parity gives kind 4 (violation) and starts no sequence.
- R9: In interruptible mode, a nonzero control sample during a sequence ends it. That character then gets its normally decoded kind with step 0, and if it is itself a start condition, a new sequence begins at step 0.
- R10: In interruptible mode with parity checking on, a bad-parity character during a sequence gives kind 4 and ends the sequence, whatever the control bits are.
- R11: Outside a sequence, a bad-parity character gives kind 4 when checking is on. With checking off, parity has no effect in either mode.
- R12: `step_o` is 0 whenever `kind_o` is not 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst | input | 1 | Synchronous active-high reset |
| intr_mode_i | input | 1 | 1 = interruptible sequence, 0 = atomic |
| par_chk_i | input | 1 | Enables odd-parity checking |
| sel_enc_i | input | 1 | 1 = control decode uses the select bit |
| ctl_i | input | 2 | Character control field |
| sel_i | input | 1 | Select bit |
| data_i | input | 8 | Data byte |
| par_i | input | 1 | Odd parity bit over `data_i` |
| kind_o | output | 3 | 0 data, 1 fill, 2 special, 3 sync step, 4 violation |
| step_o | output | 4 | Sync sequence step index |
| data_o | output | 8 | Registered data byte |

## Verification
The decode tables are swept in both select settings with parity off, so that only the control mapping can affect the kind. Sequences are run in atomic mode with noisy control bits and bad parity in the middle, which separates atomic behaviour from interruptible behaviour. Back-to-back starts at step 15 are tried as well. In interruptible mode, breaks by fill, special and fresh start codes, and by a mid-sequence parity error, show whether the abort and the restart are handled apart. A long mixed run switches modes while a sequence is in progress, and a behavioural model checks every cycle.

// File: rtl/wsync_pkg.sv
package wsync_pkg;
  typedef enum logic [2:0] {
    CH_DATA    = 3'd0,
    CH_FILL    = 3'd1,
    CH_SPECIAL = 3'd2,
    CH_SYNC    = 3'd3,
    CH_VIOL    = 3'd4
  } chr_kind_t;
endpackage

// File: rtl/wsync_decode.sv
module wsync_decode
  import wsync_pkg::*;
(
  input  logic [1:0] ctl,
  input  logic       sel,
  input  logic       use_sel,
  output chr_kind_t  kind,
  output logic       start
);
  always_comb begin
    if (use_sel) begin
      start = sel & ctl[0];
      if (!ctl[0])      kind = CH_DATA;
      else if (sel)     kind = CH_SYNC;
      else if (ctl[1])  kind = CH_SPECIAL;
      else              kind = CH_FILL;
    end else begin
      start = &ctl;
      case (ctl)
        2'b00:   kind = CH_DATA;
        2'b01:   kind = CH_FILL;
        2'b10:   kind = CH_SPECIAL;
        default: kind = CH_SYNC;
      endcase
    end
  end
endmodule

// File: rtl/wsync_parity.sv
module wsync_parity #(
  parameter int DATA_W = 8,
  parameter bit ODD    = 1'b1
) (
  input  logic [DATA_W-1:0] data,
  input  logic              par,
  output logic              ok
);
  generate
    if (ODD) begin : g_odd
      assign ok = ^{data, par};
    end else begin : g_even
      assign ok = ~^{data, par};
    end
  endgenerate
endmodule

// File: rtl/wsync_seq_fsm.sv
module wsync_seq_fsm
  import wsync_pkg::*;
#(
  parameter int STEPS  = 16,
  localparam int STEP_W = $clog2(STEPS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              intr_mode,
  input  logic              chk_en,
  input  logic              par_ok,
  input  logic [1:0]        ctl,
  input  chr_kind_t         dec_kind,
  input  logic              dec_start,
  output chr_kind_t         kind_n,
  output logic [STEP_W-1:0] step_n
);
  localparam logic [STEP_W-1:0] LAST = STEP_W'(STEPS - 1);

  logic              in_seq, in_seq_n;
  logic [STEP_W-1:0] idx, idx_n;
  logic              bad, quiet, advance;

  assign bad     = chk_en & ~par_ok;
  assign quiet   = (ctl == 2'b00);
  assign advance = in_seq & (~intr_mode | (quiet & ~bad));

  always_comb begin
    kind_n   = dec_kind;
    step_n   = '0;
    in_seq_n = 1'b0;
    idx_n    = '0;
    if (advance) begin
      kind_n = CH_SYNC;
      step_n = idx;
      if (idx != LAST) begin
        in_seq_n = 1'b1;
        idx_n    = idx + 1'b1;
      end
    end else if (bad) begin
      kind_n = CH_VIOL;
    end else if (dec_start) begin
      kind_n   = CH_SYNC;
      in_seq_n = 1'b1;
      idx_n    = STEP_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      in_seq <= 1'b0;
      idx    <= '0;
    end else begin
      in_seq <= in_seq_n;
      idx    <= idx_n;
    end
  end
endmodule

// File: rtl/wsync_ctrl.sv
module wsync_ctrl
  import wsync_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int STEPS  = 16,
  localparam int STEP_W = $clog2(STEPS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              intr_mode_i,
  input  logic              par_chk_i,
  input  logic              sel_enc_i,
  input  logic [1:0]        ctl_i,
  input  logic              sel_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              par_i,
  output logic [2:0]        kind_o,
  output logic [STEP_W-1:0] step_o,
  output logic [DATA_W-1:0] data_o
);
  chr_kind_t         dec_kind, kind_n;
  logic              dec_start, par_ok;
  logic [STEP_W-1:0] step_n;

  wsync_decode u_dec (
    .ctl     (ctl_i),
    .sel     (sel_i),
    .use_sel (sel_enc_i),
    .kind    (dec_kind),
    .start   (dec_start)
  );

  wsync_parity #(.DATA_W(DATA_W), .ODD(1'b1)) u_par (
    .data (data_i),
    .par  (par_i),
    .ok   (par_ok)
  );

  wsync_seq_fsm #(.STEPS(STEPS)) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .intr_mode (intr_mode_i),
    .chk_en    (par_chk_i),
    .par_ok    (par_ok),
    .ctl       (ctl_i),
    .dec_kind  (dec_kind),
    .dec_start (dec_start),
    .kind_n    (kind_n),
    .step_n    (step_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      kind_o <= CH_FILL;
      step_o <= '0;
      data_o <= '0;
    end else begin
      kind_o <= kind_n;
      step_o <= step_n;
      data_o <= data_i;
    end
  end
endmodule

// File: rtl/wsync_ctrl_chk.sv
module wsync_ctrl_chk #(
  parameter int DATA_W = 8,
  parameter int STEPS  = 16,
  localparam int STEP_W = $clog2(STEPS)
) (
  input logic              clk,
  input logic              rst,
  input logic              intr_mode_i,
  input logic              par_chk_i,
  input logic [1:0]        ctl_i,
  input logic [DATA_W-1:0] data_i,
  input logic              par_i,
  input logic [2:0]        kind_o,
  input logic [STEP_W-1:0] step_o,
  input logic [DATA_W-1:0] data_o
);
  localparam logic [STEP_W-1:0] LAST = STEP_W'(STEPS - 1);
  logic mid, bad_in;
  assign mid    = (kind_o == 3'd3) && (step_o != LAST);
  assign bad_in = par_chk_i && !(^{data_i, par_i});

  a_r1_reset_state: assert property (@(posedge clk) rst |=> (kind_o == 3'd1 && step_o == '0));
  a_r2_data_pass: assert property (@(posedge clk) disable iff (rst) 1'b1 |=> data_o == $past(data_i));
  a_r12_step_zero: assert property (@(posedge clk) disable iff (rst) (kind_o != 3'd3) |-> step_o == '0);
  a_r6_atomic_advance: assert property (@(posedge clk) disable iff (rst)
    (mid && !intr_mode_i) |=> (kind_o == 3'd3 && step_o == $past(step_o) + 1'b1));
  a_r9_intr_break: assert property (@(posedge clk) disable iff (rst)
    (mid && intr_mode_i && ctl_i != 2'b00) |=> step_o == '0);
  a_r10_par_abort: assert property (@(posedge clk) disable iff (rst)
    (mid && intr_mode_i && bad_in) |=> kind_o == 3'd4);
  a_r11_idle_par: assert property (@(posedge clk) disable iff (rst)
    (!mid && bad_in) |=> kind_o == 3'd4);
endmodule

bind wsync_ctrl wsync_ctrl_chk #(.DATA_W(DATA_W), .STEPS(STEPS)) u_chk (
  .clk(clk), .rst(rst), .intr_mode_i(intr_mode_i), .par_chk_i(par_chk_i),
  .ctl_i(ctl_i), .data_i(data_i), .par_i(par_i),
  .kind_o(kind_o), .step_o(step_o), .data_o(data_o)
);

// File: tb/wsync_ctrl_tb.sv
module wsync_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       intr_mode_i = 1'b0, par_chk_i = 1'b0, sel_enc_i = 1'b0;
  logic [1:0] ctl_i = 2'b00;
  logic       sel_i = 1'b0;
  logic [7:0] data_i = 8'h00;
  logic       par_i = 1'b1;
  logic [2:0] kind_o;
  logic [3:0] step_o;
  logic [7:0] data_o;

  int n_chk = 0, n_bad = 0;
  bit m_in = 0;
  int m_idx = 0;

  always #5 clk = ~clk;

  wsync_ctrl u_dut (
    .clk(clk), .rst(rst), .intr_mode_i(intr_mode_i), .par_chk_i(par_chk_i),
    .sel_enc_i(sel_enc_i), .ctl_i(ctl_i), .sel_i(sel_i), .data_i(data_i),
    .par_i(par_i), .kind_o(kind_o), .step_o(step_o), .data_o(data_o)
  );

  function automatic int ref_kind(input logic [1:0] c, input logic s, input logic u);
    if (u) begin
      if (c[0] == 1'b0) return 0;
      if (s) return 3;
      return (c == 2'b11) ? 2 : 1;
    end
    return int'(c);
  endfunction

  task automatic check(input string tag, input int ek, input int es, input int ed);
    n_chk++;
    if (int'(kind_o) != ek || int'(step_o) != es || int'(data_o) != ed) begin
      n_bad++;
      $display("FAIL %s: kind/step/data = %0d/%0d/%02h, expected %0d/%0d/%02h",
               tag, kind_o, step_o, data_o, ek, es, ed);
    end
  endtask

  task automatic put(input logic [1:0] c, input logic s, input logic [7:0] d,
                     input bit good, input string tag);
    logic p;
    bit   bad;
    int   ek, es, k;
    p = good ? ~^d : ^d;
    @(negedge clk);
    ctl_i = c; sel_i = s; data_i = d; par_i = p;
    @(posedge clk);
    #1;
    bad = par_chk_i && (^{d, p} == 1'b0);
    if (m_in && (!intr_mode_i || (!bad && c == 2'b00))) begin
      ek = 3; es = m_idx; m_idx++;
      if (m_idx == 16) begin m_in = 0; m_idx = 0; end
    end else begin
      m_in = 0; m_idx = 0; es = 0;
      if (bad) ek = 4;
      else begin
        k = ref_kind(c, s, sel_enc_i);
        ek = k;
        if (k == 3) begin m_in = 1; m_idx = 1; end
      end
    end
    check(tag, ek, es, int'(d));
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #2000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish_run();
  end

  initial begin
    repeat (2) @(posedge clk);
    #1;
    check("R1", 1, 0, 0);
    @(negedge clk); rst = 1'b0;

    // R3 plain decode, R2 data pass
    put(2'b00, 0, 8'h3C, 1, "R3"); put(2'b01, 1, 8'hA5, 1, "R3");
    put(2'b10, 0, 8'h00, 0, "R3"); put(2'b00, 1, 8'hFF, 1, "R2");
    // R4 select decode
    sel_enc_i = 1;
    put(2'b10, 1, 8'h11, 1, "R4"); put(2'b00, 0, 8'h22, 1, "R4");
    put(2'b01, 0, 8'h33, 1, "R4"); put(2'b11, 0, 8'h44, 1, "R4");
    put(2'b10, 0, 8'h55, 1, "R4");
    // R5/R6 atomic sequence via select, noisy controls and bad parity
    par_chk_i = 1;
    put(2'b01, 1, 8'h66, 1, "R5");
    for (int i = 1; i < 16; i++) put(2'(i), i[0], 8'(i * 7), (i % 3) != 0, "R6");
    // R7 back-to-back restart
    sel_enc_i = 0;
    put(2'b11, 0, 8'h77, 1, "R7");
    for (int i = 1; i < 16; i++) put(2'b00, 0, 8'(i), 1, "R6");
    put(2'b11, 0, 8'h88, 1, "R7");
    for (int i = 1; i < 16; i++) put(2'b10, 0, 8'(i), 1, "R6");
    // R8 bad parity on start
    put(2'b11, 0, 8'h99, 0, "R8"); put(2'b00, 0, 8'h01, 1, "R8");
    // R11 parity ignored when off, violation when on
    par_chk_i = 0; put(2'b01, 0, 8'h0F, 0, "R11"); put(2'b11, 0, 8'h0E, 0, "R11");
    for (int i = 1; i < 16; i++) put(2'b00, 0, 8'(i), 0, "R11");
    par_chk_i = 1; put(2'b01, 0, 8'h0F, 0, "R11");
    // interruptible
    intr_mode_i = 1;
    put(2'b11, 0, 8'hA0, 1, "R5");
    for (int i = 1; i < 16; i++) put(2'b00, 0, 8'(i), 1, "R5");
    put(2'b11, 0, 8'hA1, 1, "R9");
    for (int i = 1; i < 5; i++) put(2'b00, 0, 8'(i), 1, "R9");
    put(2'b01, 0, 8'hB0, 1, "R9"); put(2'b00, 0, 8'hB1, 1, "R9");
    put(2'b11, 0, 8'hB2, 1, "R9"); put(2'b00, 0, 8'hB3, 1, "R9");
    put(2'b11, 0, 8'hB4, 1, "R9"); put(2'b00, 0, 8'hB5, 1, "R9");
    put(2'b10, 0, 8'hB6, 1, "R9");
    put(2'b11, 0, 8'hC0, 1, "R10"); put(2'b00, 0, 8'hC1, 1, "R10");
    put(2'b00, 0, 8'hC2, 0, "R10"); put(2'b00, 0, 8'hC3, 1, "R10");
    put(2'b11, 0, 8'hC4, 1, "R10"); put(2'b11, 0, 8'hC5, 0, "R10");
    put(2'b00, 0, 8'hC6, 0, "R11");
    // mixed run
    for (int i = 0; i < 600; i++) begin
      if (i % 45 == 0) begin
        intr_mode_i = $urandom_range(0, 1); par_chk_i = $urandom_range(0, 1);
        sel_enc_i = $urandom_range(0, 1);
      end
      put(($urandom_range(0, 3) == 0) ? 2'($urandom) : 2'b00, 1'($urandom),
          8'($urandom), $urandom_range(0, 9) != 0, "R12");
      if (i % 20 == 0) put(2'b11, 1, 8'($urandom), 1, "R12");
    end
    finish_run();
  end
endmodule